// File: doc/BRIEF.md
# Gray-Ordered Block Address Generator

This block issues a stream of data-memory word addresses that walks an array in blocks of `uf` elements, where `uf = 2^log_uf`. Each block starts at an element index that is a multiple of `uf`. Inside a block, the low offset steps through the reflected Gray order (0, 1, 3, 2, 6, 7, 5, 4, ...), so consecutive references differ in a single offset bit. The upper part of the index moves forward in binary by `uf` from one block to the next. One address is issued per clock while the valid strobe is high.

While it runs, the block keeps two tallies of bit toggles on the address bus. A toggle is any bit that changes between two consecutive issued addresses. The within-block tally covers address pairs that fall inside the same block. The between-block tally covers the pair formed by the last address of one block and the first address of the next. These tallies let a designer compare the switching activity of different unroll factors and base alignments.

Control is a three-state machine: `ST_IDLE`, `ST_RUN` and `ST_FINISH`. Its transitions are:
- `ST_IDLE` to `ST_RUN`: start with a nonzero count.
- `ST_IDLE` to `ST_FINISH`: start with a zero count.
- `ST_RUN` to `ST_RUN`: more addresses remain to be issued.
- `ST_RUN` to `ST_FINISH`: the final address is being issued.
- `ST_FINISH` to `ST_IDLE`: always, after one cycle.

Top module: `gray_block_addr_gen`

## Requirements
- R1: A synchronous reset, including one applied in the middle of a run, leaves `valid_o` and `done_o` low and both toggle counters at zero.
- R2: A start accepted in `ST_IDLE` latches the base, the count and the log unroll factor, and clears both counters. The first address appears in the following cycle, and one address is issued per cycle while `valid_o` is high.
- R3: The k-th address of block j equals `base + j*uf + (k ^ (k>>1))`, taken modulo 2^ADDR_W, for k = 0 to uf-1. For example, with uf = 4 the offsets run 0, 1, 3, 2.
- R4: The within-block counter adds `popcount(prev ^ curr)` for each pair of consecutive addresses in the same block. When the base is a multiple of `uf`, this gives exactly uf-1 per block.
- R5: The between-block counter adds `popcount(prev ^ curr)` for each pair that crosses a block boundary. The first address of a run adds nothing. With log_uf = 0 every pair is a boundary pair.
- R6: After exactly `count_i` addresses, `valid_o` falls and `done_o` is high for exactly one cycle, namely the cycle right after the last address.
- R7: Once a run ends, both counters hold their values until the next accepted start.
- R8: A start that arrives in `ST_RUN` or `ST_FINISH` is ignored. The address sequence, the counters and the return to `ST_IDLE` are unchanged.
- R9: A start with `count_i` = 0 issues no address and raises `done_o` one cycle later, with both counters at zero.
- R10: A `log_uf_i` value above `LOG_UF_MAX` is treated as `LOG_UF_MAX`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, accepted only in idle |
| base_i | input | ADDR_W | Array base address |
| count_i | input | N_W | Number of addresses to issue |
| log_uf_i | input | LU_W | log2 of the unroll factor |
| addr_o | output | ADDR_W | Issued address |
| valid_o | output | 1 | Address strobe |
| done_o | output | 1 | One-cycle end-of-run pulse |
| intra_cnt_o | output | CNT_W | Within-block toggle total |
| inter_cnt_o | output | CNT_W | Between-block toggle total |

## Verification
The hardest situations to reach from the ports are a start that lands while a run is in progress and a start that lands in the single `ST_FINISH` cycle. Either one could corrupt the latched parameters or clear the counters. The bench injects a conflicting start on a chosen address index in the middle of a run, and a second one on the exact cycle that `done_o` is high. It then checks that the original sequence, the final totals and the return to idle are untouched. It also drives an unaligned base and a base near the top of the address space. With these inputs the toggle totals no longer follow the uf-1 pattern, and the wrap shows up as a wide between-block toggle.

// File: rtl/gab_pkg.sv
package gab_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } gab_state_e;
endpackage

// File: rtl/gab_offset_walk.sv
// Walks the in-block position k and presents its reflected Gray code.
module gab_offset_walk #(
    parameter int KW   = 4,
    parameter int LU_W = 3
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            clear_i,
    input  logic            advance_i,
    input  logic [LU_W-1:0] log_uf_i,
    output logic [KW-1:0]   gray_o,
    output logic            first_o,
    output logic            last_o
);
    logic [KW-1:0] k_q;
    logic [KW-1:0] k_mask;

    // Mask of the low log_uf bits, i.e. uf-1.
    always_comb begin
        for (int b = 0; b < KW; b++) begin
            k_mask[b] = (b < int'(log_uf_i));
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            k_q <= '0;
        end else if (advance_i) begin
            k_q <= (k_q == k_mask) ? '0 : k_q + 1'b1;
        end
    end

    assign gray_o  = k_q ^ (k_q >> 1);
    assign first_o = (k_q == '0);
    assign last_o  = (k_q == k_mask);
endmodule

// File: rtl/gab_toggle_acc.sv
// Accumulates the number of differing bits between two address words.
module gab_toggle_acc #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 17
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              clear_i,
    input  logic              en_i,
    input  logic [ADDR_W-1:0] prev_i,
    input  logic [ADDR_W-1:0] curr_i,
    output logic [CNT_W-1:0]  count_o
);
    localparam int PC_W = $clog2(ADDR_W + 1);

    logic [ADDR_W-1:0] diff;
    logic [PC_W-1:0]   pc;
    logic [CNT_W-1:0]  count_q;

    assign diff = prev_i ^ curr_i;

    always_comb begin
        pc = '0;
        for (int b = 0; b < ADDR_W; b++) begin
            pc = pc + PC_W'(diff[b]);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            count_q <= '0;
        end else if (en_i) begin
            count_q <= count_q + CNT_W'(pc);
        end
    end

    assign count_o = count_q;
endmodule

// File: rtl/gray_block_addr_gen.sv
module gray_block_addr_gen
    import gab_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int N_W        = 12,
    parameter int LOG_UF_MAX = 4,
    parameter int LU_W       = $clog2(LOG_UF_MAX + 1),
    parameter int CNT_W      = N_W + $clog2(ADDR_W + 1)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [N_W-1:0]    count_i,
    input  logic [LU_W-1:0]   log_uf_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              valid_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  intra_cnt_o,
    output logic [CNT_W-1:0]  inter_cnt_o
);
    localparam int KW = LOG_UF_MAX;

    gab_state_e        state_q, state_d;
    logic              accept;
    logic [ADDR_W-1:0] base_q, blk_q, prev_q;
    logic [N_W-1:0]    rem_q;
    logic [LU_W-1:0]   log_q, log_clamped;
    logic              have_prev_q;
    logic [KW-1:0]     gray_off;
    logic              blk_first, blk_last;
    logic              en_intra, en_inter;

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = (count_i == '0) ? ST_FINISH : ST_RUN;
            ST_RUN:    if (rem_q == N_W'(1)) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        valid_o = 1'b0;
        done_o  = 1'b0;
        unique case (state_q)
            ST_RUN:    valid_o = 1'b1;
            ST_FINISH: done_o  = 1'b1;
            default:   ;
        endcase
    end

    assign accept      = (state_q == ST_IDLE) && start_i;
    assign log_clamped = (int'(log_uf_i) > LOG_UF_MAX) ? LU_W'(LOG_UF_MAX) : log_uf_i;

    // Run registers
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            base_q      <= '0;
            blk_q       <= '0;
            rem_q       <= '0;
            log_q       <= '0;
            prev_q      <= '0;
            have_prev_q <= 1'b0;
        end else if (accept) begin
            base_q      <= base_i;
            blk_q       <= '0;
            rem_q       <= count_i;
            log_q       <= log_clamped;
            have_prev_q <= 1'b0;
        end else if (valid_o) begin
            rem_q       <= rem_q - 1'b1;
            prev_q      <= addr_o;
            have_prev_q <= 1'b1;
            if (blk_last) blk_q <= blk_q + (ADDR_W'(1) << log_q);
        end
    end

    gab_offset_walk #(.KW(KW), .LU_W(LU_W)) u_walk (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .clear_i   (accept),
        .advance_i (valid_o),
        .log_uf_i  (log_q),
        .gray_o    (gray_off),
        .first_o   (blk_first),
        .last_o    (blk_last)
    );

    assign addr_o   = base_q + blk_q + ADDR_W'(gray_off);
    assign en_intra = valid_o && have_prev_q && !blk_first;
    assign en_inter = valid_o && have_prev_q && blk_first;

    gab_toggle_acc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_intra (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clear_i (accept),
        .en_i    (en_intra),
        .prev_i  (prev_q),
        .curr_i  (addr_o),
        .count_o (intra_cnt_o)
    );

    gab_toggle_acc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_inter (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clear_i (accept),
        .en_i    (en_inter),
        .prev_i  (prev_q),
        .curr_i  (addr_o),
        .count_o (inter_cnt_o)
    );
endmodule

// File: rtl/gab_checker.sv
module gab_checker #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 17
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              start_i,
    input logic              valid_o,
    input logic              done_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic [CNT_W-1:0]  intra_cnt_o,
    input logic [CNT_W-1:0]  inter_cnt_o
);
    a_r6_done_single: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    a_r6_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
        !(valid_o && done_o));

    a_r7_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (!valid_o && !start_i) |=> ($stable(intra_cnt_o) && $stable(inter_cnt_o)));

    a_r4_monotonic: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |=> (intra_cnt_o >= $past(intra_cnt_o) && inter_cnt_o >= $past(inter_cnt_o)));

    a_r3_distinct: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_o && $past(valid_o)) |-> (addr_o != $past(addr_o)));
endmodule

bind gray_block_addr_gen gab_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_gab_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .start_i     (start_i),
    .valid_o     (valid_o),
    .done_o      (done_o),
    .addr_o      (addr_o),
    .intra_cnt_o (intra_cnt_o),
    .inter_cnt_o (inter_cnt_o)
);

// File: tb/gray_block_addr_gen_tb.sv
module gray_block_addr_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int N_W    = 12;
    localparam int LUMAX  = 4;
    localparam int LU_W   = 3;
    localparam int CNT_W  = N_W + $clog2(ADDR_W + 1);
    localparam int NV     = 6;

    // base, count, log_uf, expected intra, expected inter
    localparam logic [15:0] V_BASE  [NV] = '{16'd0, 16'd0, 16'd0, 16'd5, 16'hFFFC, 16'd0};
    localparam int          V_N     [NV] = '{8, 4, 16, 8, 8, 32};
    localparam int          V_LOG   [NV] = '{2, 0, 3, 2, 2, 7};
    localparam int          V_INTRA [NV] = '{6, 0, 14, 16, 6, 30};
    localparam int          V_INTER [NV] = '{2, 4, 2, 3, 15, 2};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] base = '0;
    logic [N_W-1:0]    count = '0;
    logic [LU_W-1:0]   log_uf = '0;
    logic [ADDR_W-1:0] addr;
    logic              valid, done;
    logic [CNT_W-1:0]  intra, inter;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gray_block_addr_gen #(.ADDR_W(ADDR_W), .N_W(N_W), .LOG_UF_MAX(LUMAX)) dut_i (
        .clk_i(clk), .rst_i(rst), .start_i(start), .base_i(base), .count_i(count),
        .log_uf_i(log_uf), .addr_o(addr), .valid_o(valid), .done_o(done),
        .intra_cnt_o(intra), .inter_cnt_o(inter)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one sequence; poke_idx >= 0 injects a conflicting start at that address index,
    // poke_done injects one on the done cycle.
    task automatic run_seq(input logic [15:0] b, input int n, input int lg,
                           input int e_intra, input int e_inter,
                           input int poke_idx, input bit poke_done);
        int eff = (lg > LUMAX) ? LUMAX : lg;
        int uf  = 1 << eff;
        int idx = 0;
        int guard = 0;
        @(negedge clk);
        base = b; count = N_W'(n); log_uf = LU_W'(lg); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && guard < 400) begin
            if (valid) begin
                int k = idx & (uf - 1);
                logic [15:0] ea = b + 16'((idx - k) + (k ^ (k >> 1)));
                chk(addr == ea, "R3 address", addr, ea);
                idx++;
            end
            if (idx == poke_idx && poke_idx >= 0) begin
                base = 16'd999; count = 12'd3; log_uf = 3'd1; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            guard++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(idx == n, "R6 address count", idx, n);
        chk(done && !valid, "R6 done after last", done, 1);
        chk(intra == CNT_W'(e_intra), "R4 intra total", intra, e_intra);
        chk(inter == CNT_W'(e_inter), "R5 inter total", inter, e_inter);
        if (poke_done) begin
            base = 16'd77; count = 12'd4; log_uf = 3'd0; start = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        chk(!done, "R6 done single cycle", done, 0);
        if (poke_done) chk(!valid, "R8 start in finish ignored", valid, 0);
        repeat (3) @(negedge clk);
        chk(!valid, "R8 stays idle", valid, 0);
        chk(intra == CNT_W'(e_intra) && inter == CNT_W'(e_inter), "R7 counters hold",
            intra, e_intra);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!valid && !done, "R1 reset outputs", valid, 0);
        chk(intra == 0 && inter == 0, "R1 reset counters", intra + inter, 0);
        rst = 1'b0;
        @(negedge clk);

        // R2 R3 R4 R5 R10: table walk
        for (int v = 0; v < NV; v++) begin
            run_seq(V_BASE[v], V_N[v], V_LOG[v], V_INTRA[v], V_INTER[v], -1, 1'b0);
        end

        // R2: first address one cycle after start
        @(negedge clk);
        base = 16'd40; count = 12'd4; log_uf = 3'd2; start = 1'b1;
        chk(!valid, "R2 no address during start cycle", valid, 0);
        @(negedge clk);
        start = 1'b0;
        chk(valid && addr == 16'd40, "R2 first address", addr, 40);
        repeat (6) @(negedge clk);

        // R8: start during run and during finish are ignored
        run_seq(16'd0, 8, 2, 6, 2, 2, 1'b1);

        // R9: zero count
        @(negedge clk);
        base = 16'd3; count = 12'd0; log_uf = 3'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done && !valid, "R9 done without addresses", done, 1);
        chk(intra == 0 && inter == 0, "R9 counters cleared", intra + inter, 0);
        repeat (2) @(negedge clk);

        // R1: reset mid-run
        base = 16'd0; count = 12'd16; log_uf = 3'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        chk(intra != 0, "R1 run progressed", intra, 1);
        rst = 1'b1;
        @(negedge clk);
        chk(!valid && !done && intra == 0 && inter == 0, "R1 mid-run reset", intra, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule